// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer with a 32-bit register interface. Its down-counter advances only on a slow tick strobe that comes from a separate low-speed time base. Software arms it, feeds it and opens or closes its settings by writing magic values to a key register. Once armed, the counter cannot be halted by software. If software stops feeding it, the block raises a one-cycle reset request toward the system reset controller. It can also raise an early-warning interrupt at a chosen count before the deadline.

The divider code and reload value set the timeout. The early-warning compare value sets when the warning fires. The counter side reads these settings only on tick edges. Each accepted write therefore raises a busy flag in the status register until the next tick takes the value over. Software polls these flags before relying on a new setting.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, status (0x00C) reads 0, reload (0x008) reads 0xFFF, divider code (0x004) reads 0, early-warning control (0x014) reads 0, and both outputs are low. The low byte of address 0x3F4 reads the REVISION parameter.
- R2: Writing 0x5555 to the key address 0x000 opens the settings. Any other key value closes them, including 0x0000, 0xAAAA, 0xCCCC and undefined values. Only bits 15:0 of a key write are decoded. While the settings are closed, writes to 0x004, 0x008 and 0x014 leave their read-back unchanged.
- R3: An accepted write sets a busy flag in the status register: bit 0 for the divider code, bit 1 for reload and bit 3 for early warning. Bit 2 always reads 0. Each flag clears at the next tick, whether or not the counter is running.
- R4: Key 0xCCCC arms the watchdog, and status bit 8 reads 1 from the next clock. Only a block reset clears it.
- R5: The counter loads the reload value R on the first tick after arming. It then steps once every D ticks, where D = 4 << code. A reset request, one clock long, follows the step taken from count 0. That step comes 1 + D*(R+1) ticks after the arm key.
- R6: After a reset request the counter reloads from R. The next request follows after a further D*(R+1) ticks.
- R7: Key 0xAAAA reloads the counter on the next tick, and that tick does not count toward the prescaler. While the watchdog is unarmed, this key leaves status bit 8 at 0 and no reset request ever follows.
- R8: When bit 15 of 0x014 is set and a step lands the counter on the compare value in bits 11:0, the early-warning interrupt sets. It stays high until it is cleared.
- R9: A write to 0x014 with bit 14 set clears a pending early-warning interrupt, whether the settings are open or closed. Bit 14 is not stored and reads 0.
- R10: Divider codes of 6 and above divide the tick by 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low block reset |
| tick | input | 1 | One-cycle strobe from the low-speed time base |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wdg_reset_req | output | 1 | One-cycle reset request on expiry |
| early_irq | output | 1 | Pending early-warning interrupt |

## Verification
The hardest state to reach from the ports is one in which the counter's position matters. Examples are the tick on which the compare value is hit, or a feed that lands just before expiry. No register exposes the count. The stimulus therefore sends ticks in exact bursts, counted from the arm or feed key, and counts reset-request pulses inside each burst. This puts a pulse on a known tick, and places the early-warning set on the single tick predicted from R, D and the compare value.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   // register byte offsets (12-bit view)
   localparam logic [11:0] OFS_KEY = 12'h000;
   localparam logic [11:0] OFS_DIV = 12'h004;
   localparam logic [11:0] OFS_RLD = 12'h008;
   localparam logic [11:0] OFS_STS = 12'h00C;
   localparam logic [11:0] OFS_EW  = 12'h014;
   localparam logic [11:0] OFS_VER = 12'h3F4;

   // key words
   localparam logic [15:0] KEY_OPEN = 16'h5555;
   localparam logic [15:0] KEY_FEED = 16'hAAAA;
   localparam logic [15:0] KEY_ARM  = 16'hCCCC;

   // status bit positions
   localparam int ST_DIV = 0;
   localparam int ST_RLD = 1;
   localparam int ST_EW  = 3;
   localparam int ST_RUN = 8;

   // early-warning control bit positions
   localparam int EW_ENA = 15;
   localparam int EW_CLR = 14;
endpackage

// File: rtl/wdg_keydec.sv
module wdg_keydec
   import wdg_pkg::*;
(
   input  logic [15:0] key,
   output logic        is_open,
   output logic        is_arm,
   output logic        is_feed
);
   assign is_open = (key == KEY_OPEN);
   assign is_arm  = (key == KEY_ARM);
   assign is_feed = (key == KEY_FEED);
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int         CNT_W    = 12,
   parameter int         PRE_W    = 4,
   parameter int         ADDR_W   = 12,
   parameter logic [7:0] REVISION = 8'h32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [PRE_W-1:0]  div_q,
   output logic [CNT_W-1:0]  rld_q,
   output logic              ew_en_q,
   output logic [CNT_W-1:0]  ew_cmp_q,
   output logic              run_q,
   output logic              feed_q,
   output logic              open_q,
   output logic              ew_clr,
   output logic [3:0]        busy_q
);
   localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(OFS_KEY);
   localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(OFS_DIV);
   localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(OFS_RLD);
   localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
   localparam logic [ADDR_W-1:0] A_EW  = ADDR_W'(OFS_EW);
   localparam logic [ADDR_W-1:0] A_VER = ADDR_W'(OFS_VER);

   logic key_wr, div_wr, rld_wr, ew_wr;
   logic k_open, k_arm, k_feed;
   wire  unused_wd = ^bus_wdata;

   assign key_wr = bus_we && (bus_addr == A_KEY);
   assign div_wr = bus_we && (bus_addr == A_DIV);
   assign rld_wr = bus_we && (bus_addr == A_RLD);
   assign ew_wr  = bus_we && (bus_addr == A_EW);
   assign ew_clr = ew_wr && bus_wdata[EW_CLR];

   wdg_keydec u_keydec (
      .key     (bus_wdata[15:0]),
      .is_open (k_open),
      .is_arm  (k_arm),
      .is_feed (k_feed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q   <= 1'b0;
         run_q    <= 1'b0;
         feed_q   <= 1'b0;
         div_q    <= '0;
         rld_q    <= '1;
         ew_en_q  <= 1'b0;
         ew_cmp_q <= '0;
         busy_q   <= '0;
      end else begin
         // the counter side takes every setting on a tick edge
         if (tick) begin
            busy_q <= '0;
            feed_q <= 1'b0;
         end
         if (key_wr) begin
            open_q <= k_open;
            if (k_arm) begin
               run_q  <= 1'b1;
               feed_q <= 1'b1;
            end
            if (k_feed) feed_q <= 1'b1;
         end
         if (div_wr && open_q) begin
            div_q          <= bus_wdata[PRE_W-1:0];
            busy_q[ST_DIV] <= 1'b1;
         end
         if (rld_wr && open_q) begin
            rld_q          <= bus_wdata[CNT_W-1:0];
            busy_q[ST_RLD] <= 1'b1;
         end
         if (ew_wr && open_q) begin
            ew_en_q       <= bus_wdata[EW_ENA];
            ew_cmp_q      <= bus_wdata[CNT_W-1:0];
            busy_q[ST_EW] <= 1'b1;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_STS) begin
         bus_rdata[3:0]    = busy_q;
         bus_rdata[ST_RUN] = run_q;
      end else if (bus_addr == A_DIV) begin
         bus_rdata[PRE_W-1:0] = div_q;
      end else if (bus_addr == A_RLD) begin
         bus_rdata[CNT_W-1:0] = rld_q;
      end else if (bus_addr == A_EW) begin
         bus_rdata[EW_ENA]     = ew_en_q;
         bus_rdata[CNT_W-1:0]  = ew_cmp_q;
      end else if (bus_addr == A_VER) begin
         bus_rdata[7:0] = REVISION;
      end
   end
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
   parameter int CNT_W   = 12,
   parameter int PRE_W   = 4,
   parameter int PRE_TOP = 6,
   parameter bit HAS_EW  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             feed,
   input  logic [PRE_W-1:0] div_code,
   input  logic [CNT_W-1:0] rld,
   input  logic             ew_en,
   input  logic [CNT_W-1:0] ew_cmp,
   input  logic             ew_clr,
   output logic             rst_req,
   output logic             ew_irq
);
   localparam int PSC_W = PRE_TOP + 2;

   logic [PRE_W-1:0] code_sat;
   logic [PSC_W:0]   div_v;
   logic [PSC_W-1:0] psc_last;
   logic [PSC_W-1:0] psc_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             step;

   assign code_sat = (div_code > PRE_W'(PRE_TOP)) ? PRE_W'(PRE_TOP) : div_code;
   assign div_v    = (PSC_W+1)'(1) << (32'(code_sat) + 2);
   assign psc_last = PSC_W'(div_v - 1'b1);
   assign cnt_nxt  = (cnt_q == '0) ? rld : cnt_q - 1'b1;
   assign step     = tick && run && !feed && (psc_q >= psc_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_q   <= '0;
         cnt_q   <= '1;
         rst_req <= 1'b0;
      end else begin
         rst_req <= 1'b0;
         if (tick) begin
            if (feed) begin
               cnt_q <= rld;
               psc_q <= '0;
            end else if (run) begin
               if (step) begin
                  psc_q <= '0;
                  cnt_q <= cnt_nxt;
                  if (cnt_q == '0) rst_req <= 1'b1;
               end else begin
                  psc_q <= psc_q + 1'b1;
               end
            end
         end
      end
   end

   generate
      if (HAS_EW) begin : g_ew
         logic pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q <= 1'b0;
            end else begin
               if (ew_clr) pend_q <= 1'b0;
               if (step && ew_en && (cnt_nxt == ew_cmp)) pend_q <= 1'b1;
            end
         end
         assign ew_irq = pend_q;
      end else begin : g_no_ew
         wire unused_ew = ew_en ^ ew_clr ^ (^ew_cmp);
         assign ew_irq = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
   import wdg_pkg::*;
#(
   parameter int         CNT_W    = 12,
   parameter int         PRE_W    = 4,
   parameter int         PRE_TOP  = 6,
   parameter int         ADDR_W   = 12,
   parameter logic [7:0] REVISION = 8'h32,
   parameter bit         HAS_EW   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              wdg_reset_req,
   output logic              early_irq
);
   generate
      if (CNT_W < 4 || CNT_W > 14) begin : g_bad_cnt
         $error("CNT_W must lie in 4..14");
      end
      if (ADDR_W < 10) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
      if (PRE_TOP < 0 || PRE_TOP >= (1 << PRE_W)) begin : g_bad_pre
         $error("PRE_TOP must be a valid divider code");
      end
   endgenerate

   logic [PRE_W-1:0] div_val;
   logic [CNT_W-1:0] rld_val;
   logic [CNT_W-1:0] ew_cmp;
   logic             ew_en, run_q, feed_req, cfg_open, ew_clr;
   logic [3:0]       cfg_busy;

   wdg_regs #(
      .CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W), .REVISION(REVISION)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .div_q     (div_val),
      .rld_q     (rld_val),
      .ew_en_q   (ew_en),
      .ew_cmp_q  (ew_cmp),
      .run_q     (run_q),
      .feed_q    (feed_req),
      .open_q    (cfg_open),
      .ew_clr    (ew_clr),
      .busy_q    (cfg_busy)
   );

   wdg_count #(
      .CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_TOP(PRE_TOP), .HAS_EW(HAS_EW)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .run      (run_q),
      .feed     (feed_req),
      .div_code (div_val),
      .rld      (rld_val),
      .ew_en    (ew_en),
      .ew_cmp   (ew_cmp),
      .ew_clr   (ew_clr),
      .rst_req  (wdg_reset_req),
      .ew_irq   (early_irq)
   );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
   import wdg_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int CNT_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              clr_bit,
   input logic              rst_req,
   input logic              ew_irq,
   input logic              run,
   input logic [3:0]        busy,
   input logic              opened,
   input logic [CNT_W-1:0]  rld
);
   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R5
   AST_REQ_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(tick)); // R5
   AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> run); // R4
   AST_BUSY_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !bus_we) |=> (busy == 4'b0000)); // R3
   AST_CLOSED_RLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!opened && bus_we && bus_addr == ADDR_W'(OFS_RLD)) |=> $stable(rld)); // R2
   AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (ew_irq && !(bus_we && bus_addr == ADDR_W'(OFS_EW) && clr_bit)) |=> ew_irq); // R8
endmodule

bind keyed_wdog wdg_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .clr_bit  (bus_wdata[14]),
   .rst_req  (wdg_reset_req),
   .ew_irq   (early_irq),
   .run      (run_q),
   .busy     (cfg_busy),
   .opened   (cfg_open),
   .rld      (rld_val)
);

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;
   import wdg_pkg::*;

   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_IRQ = 2'd3;

   typedef struct packed {
      logic [1:0]  op;
      logic [11:0] adr;
      logic [31:0] dat;
      logic [31:0] exp;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 72;
   localparam vec_t TBL [0:NV-1] = '{
      '{OP_RD,  OFS_STS, 32'h0,    32'h0,     4'd1},   // R1
      '{OP_RD,  OFS_RLD, 32'h0,    32'hFFF,   4'd1},   // R1
      '{OP_RD,  OFS_DIV, 32'h0,    32'h0,     4'd1},   // R1
      '{OP_RD,  OFS_EW,  32'h0,    32'h0,     4'd1},   // R1
      '{OP_RD,  OFS_VER, 32'h0,    32'h32,    4'd1},   // R1
      '{OP_IRQ, OFS_KEY, 32'h0,    32'h0,     4'd1},   // R1
      '{OP_WR,  OFS_DIV, 32'h5,    32'h0,     4'd2},   // R2 closed write
      '{OP_RD,  OFS_DIV, 32'h0,    32'h0,     4'd2},
      '{OP_RD,  OFS_STS, 32'h0,    32'h0,     4'd2},
      '{OP_WR,  OFS_KEY, 32'h5555, 32'h0,     4'd3},   // R3 open
      '{OP_WR,  OFS_DIV, 32'h0,    32'h0,     4'd3},
      '{OP_RD,  OFS_STS, 32'h0,    32'h1,     4'd3},
      '{OP_WR,  OFS_RLD, 32'h3,    32'h0,     4'd3},
      '{OP_RD,  OFS_STS, 32'h0,    32'h3,     4'd3},
      '{OP_RD,  OFS_RLD, 32'h0,    32'h3,     4'd3},
      '{OP_TK,  OFS_KEY, 32'd1,    32'd0,     4'd3},
      '{OP_RD,  OFS_STS, 32'h0,    32'h0,     4'd3},
      '{OP_WR,  OFS_KEY, 32'h0,    32'h0,     4'd2},   // R2 close with 0x0000
      '{OP_WR,  OFS_RLD, 32'h7,    32'h0,     4'd2},
      '{OP_RD,  OFS_RLD, 32'h0,    32'h3,     4'd2},
      '{OP_WR,  OFS_KEY, 32'h5555, 32'h0,     4'd2},   // R2 close with bogus key
      '{OP_WR,  OFS_KEY, 32'h1234, 32'h0,     4'd2},
      '{OP_WR,  OFS_RLD, 32'h9,    32'h0,     4'd2},
      '{OP_RD,  OFS_RLD, 32'h0,    32'h3,     4'd2},
      '{OP_WR,  OFS_KEY, 32'h5555, 32'h0,     4'd3},   // R3 handshake while unarmed
      '{OP_WR,  OFS_RLD, 32'h5,    32'h0,     4'd3},
      '{OP_RD,  OFS_STS, 32'h0,    32'h2,     4'd3},
      '{OP_TK,  OFS_KEY, 32'd1,    32'd0,     4'd3},
      '{OP_RD,  OFS_STS, 32'h0,    32'h0,     4'd3},
      '{OP_RD,  OFS_RLD, 32'h0,    32'h5,     4'd3},
      '{OP_WR,  OFS_KEY, 32'hAAAA, 32'h0,     4'd7},   // R7 feed while unarmed
      '{OP_TK,  OFS_KEY, 32'd40,   32'd0,     4'd7},
      '{OP_RD,  OFS_STS, 32'h0,    32'h0,     4'd7},
      '{OP_WR,  OFS_KEY, 32'hCCCC, 32'h0,     4'd4},   // R4 arm
      '{OP_RD,  OFS_STS, 32'h0,    32'h100,   4'd4},
      '{OP_TK,  OFS_KEY, 32'd24,   32'd0,     4'd5},   // R5 1+4*6 ticks
      '{OP_TK,  OFS_KEY, 32'd1,    32'd1,     4'd5},
      '{OP_TK,  OFS_KEY, 32'd23,   32'd0,     4'd6},   // R6 period 24
      '{OP_TK,  OFS_KEY, 32'd1,    32'd1,     4'd6},
      '{OP_TK,  OFS_KEY, 32'd20,   32'd0,     4'd7},   // R7 feed before expiry
      '{OP_WR,  OFS_KEY, 32'hAAAA, 32'h0,     4'd7},
      '{OP_TK,  OFS_KEY, 32'd1,    32'd0,     4'd7},
      '{OP_TK,  OFS_KEY, 32'd23,   32'd0,     4'd7},
      '{OP_TK,  OFS_KEY, 32'd1,    32'd1,     4'd7},
      '{OP_WR,  OFS_KEY, 32'h0,    32'h0,     4'd4},   // R4 cannot stop
      '{OP_RD,  OFS_STS, 32'h0,    32'h100,   4'd4},
      '{OP_WR,  OFS_KEY, 32'h5555, 32'h0,     4'd4},
      '{OP_RD,  OFS_STS, 32'h0,    32'h100,   4'd4},
      '{OP_WR,  OFS_EW,  32'h8002, 32'h0,     4'd8},   // R8 warn at 2
      '{OP_RD,  OFS_STS, 32'h0,    32'h108,   4'd3},
      '{OP_RD,  OFS_EW,  32'h0,    32'h8002,  4'd8},
      '{OP_WR,  OFS_KEY, 32'hAAAA, 32'h0,     4'd8},
      '{OP_TK,  OFS_KEY, 32'd1,    32'd0,     4'd8},
      '{OP_RD,  OFS_STS, 32'h0,    32'h100,   4'd3},
      '{OP_TK,  OFS_KEY, 32'd11,   32'd0,     4'd8},
      '{OP_IRQ, OFS_KEY, 32'h0,    32'h0,     4'd8},
      '{OP_TK,  OFS_KEY, 32'd1,    32'd0,     4'd8},
      '{OP_IRQ, OFS_KEY, 32'h0,    32'h1,     4'd8},
      '{OP_TK,  OFS_KEY, 32'd11,   32'd0,     4'd8},
      '{OP_IRQ, OFS_KEY, 32'h0,    32'h1,     4'd8},
      '{OP_TK,  OFS_KEY, 32'd1,    32'd1,     4'd6},
      '{OP_IRQ, OFS_KEY, 32'h0,    32'h1,     4'd8},
      '{OP_WR,  OFS_EW,  32'h4000, 32'h0,     4'd9},   // R9 clear while closed
      '{OP_IRQ, OFS_KEY, 32'h0,    32'h0,     4'd9},
      '{OP_RD,  OFS_EW,  32'h0,    32'h8002,  4'd9},
      '{OP_RD,  OFS_STS, 32'h0,    32'h100,   4'd9},
      '{OP_TK,  OFS_KEY, 32'd11,   32'd0,     4'd8},   // R8 warn again at 2
      '{OP_IRQ, OFS_KEY, 32'h0,    32'h0,     4'd8},
      '{OP_TK,  OFS_KEY, 32'd1,    32'd0,     4'd8},
      '{OP_IRQ, OFS_KEY, 32'h0,    32'h1,     4'd8},
      '{OP_WR,  OFS_EW,  32'h4000, 32'h0,     4'd9},
      '{OP_IRQ, OFS_KEY, 32'h0,    32'h0,     4'd9}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wdg_reset_req, early_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   keyed_wdog u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick          (tick),
      .bus_we        (bus_we),
      .bus_addr      (bus_addr),
      .bus_wdata     (bus_wdata),
      .bus_rdata     (bus_rdata),
      .wdg_reset_req (wdg_reset_req),
      .early_irq     (early_irq)
   );

   task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d: got %h expected %h", rq, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input int rq, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(rq, bus_rdata, exp);
   endtask

   task automatic ticks(input int n, output int pulses);
      pulses = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         if (wdg_reset_req) pulses++;
         tick = 1'b0;
      end
   endtask

   initial begin
      int p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(1, {30'd0, wdg_reset_req, early_irq}, 32'd0);   // R1 outputs low

      for (int i = 0; i < NV; i++) begin
         case (TBL[i].op)
            OP_WR:  wr(TBL[i].adr, TBL[i].dat);
            OP_RD:  rd_chk(int'(TBL[i].rq), TBL[i].adr, TBL[i].exp);
            OP_TK: begin
               ticks(int'(TBL[i].dat), p);
               chk(int'(TBL[i].rq), 32'(p), TBL[i].exp);
            end
            default: begin
               @(negedge clk);
               chk(int'(TBL[i].rq), {31'd0, early_irq}, TBL[i].exp);
            end
         endcase
      end

      // R1: block reset while armed returns every register to its reset value
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd_chk(1, OFS_STS, 32'h0);
      rd_chk(1, OFS_RLD, 32'hFFF);
      rd_chk(1, OFS_EW, 32'h0);
      chk(1, {31'd0, early_irq}, 32'd0);
      ticks(50, p);
      chk(4, 32'(p), 32'd0);   // R4 reset is the only way to stop it

      // R10: divider code 6 gives divide-by-256, reload 1 -> 1 + 256*2 ticks
      wr(OFS_KEY, 32'h5555);
      wr(OFS_DIV, 32'h6);
      wr(OFS_RLD, 32'h1);
      wr(OFS_KEY, 32'hCCCC);
      ticks(1, p);
      chk(10, 32'(p), 32'd0);
      ticks(511, p);
      chk(10, 32'(p), 32'd0);
      ticks(1, p);
      chk(10, 32'(p), 32'd1);

      // R10: codes above 6 saturate at 256, R5 period with reload 1
      wr(OFS_KEY, 32'h5555);
      wr(OFS_DIV, 32'h9);
      wr(OFS_KEY, 32'hAAAA);
      ticks(1, p);
      chk(10, 32'(p), 32'd0);
      ticks(511, p);
      chk(10, 32'(p), 32'd0);
      ticks(1, p);
      chk(10, 32'(p), 32'd1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule